// File: doc/BRIEF.md
# Dual-Port Parallel I/O Controller

This block manages two 8-bit bidirectional pin groups, port A and port B, from a four-entry register interface. Each group has a direction bit that drives its tri-state output enable. A width bit in the transfer control register chooses how the groups behave. In byte mode they act as two independent ports. In word mode they act as one 16-bit port: port B is the upper byte, and its direction follows port A's direction bit.

Pin data is captured into input holding registers on each rising edge of an external strobe. The captured bytes stay there until the host reads them. When the enable bit in the control register is set, the block raises a transfer request. An acknowledge completes one transfer: in byte mode it moves one byte through port A only, and in word mode it moves both bytes. Software programs the direction, width and enable bits, then either polls the data registers or lets a DMA engine answer the requests.

Top module: `pio_dual_port`

## Requirements
- R1: While reset is active, both output enables are 0 and the request output is 0. After reset, every register reads 0, so both ports are inputs.
- R2: Register select 2 holds the direction bits: bit 0 for port A and bit 1 for port B, where 1 means output. In byte mode, `pa_oe` follows bit 0 and `pb_oe` follows bit 1.
- R3: When the width bit (bit 2 of register 3) is 1, `pb_oe` equals port A's direction bit, and port B's own direction bit has no effect.
- R4: The request output stays 0 while the enable bit (bit 0 of register 3) is 0. It is 0 from the first clock edge after the enable bit is cleared. An acknowledge given while no request is pending changes nothing.
- R5: With the enable bit set, the request rises one cycle after it is enabled. When request and acknowledge are both high at a clock edge, the request drops for one cycle and then rises again.
- R6: In byte mode, if port A is an output, an acknowledged transfer loads `wdata[7:0]` into port A's output latch and leaves port B's output untouched.
- R7: If port A is an input, an acknowledged transfer captures port A's pins. Port B's pins are also captured only in word mode.
- R8: In word mode, a write to select 0 drives `wdata[7:0]` on port A and `wdata[15:8]` on port B. A read of select 0 returns port B's held byte in bits 15:8 and port A's held byte in bits 7:0. Acknowledged transfers use the same byte order.
- R9: Both ports' pins are captured on each rising edge of `stb`, and the captured values stay unchanged until the next rising edge or the next input transfer.
- R10: In byte mode, a read of select 0 returns `{8'h00, port A held byte}` and a read of select 1 returns `{8'h00, port B held byte}`. A write to select 1 sets port B's output latch, and a write to select 0 leaves port B's output latch unchanged.
- R11: Select 2 reads back as `{14'b0, dirB, dirA}`, and select 3 reads back as `{13'b0, width, 1'b0, enable}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Write data; also the data source for output transfers |
| rdata | output | 16 | Read data for the selected register |
| stb | input | 1 | Input capture strobe, acts on its rising edge |
| xfer_req | output | 1 | Transfer request |
| xfer_ack | input | 1 | Transfer acknowledge |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |

## Verification
The assertions check on every cycle that:
- the outputs are quiet during reset;
- port B's enable tracks port A's in word mode;
- no request appears while the enable bit is clear, and the request drops after each acknowledge;
- a byte-mode transfer never touches port B's output;
- the held input bytes change only on a strobe edge or an acknowledged transfer.

Only the bench scenarios show the data path itself: which bytes land in which latch, the byte order of word reads and writes, that held data survives pin changes, and that an acknowledge without a request is ignored.

// File: rtl/pio_dual_port.sv
module pio_dual_port #(
  parameter int PW = 8,
  localparam int DW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          stb,
  output logic          xfer_req,
  input  logic          xfer_ack,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic          pb_oe
);
  logic [PW-1:0] in_a, in_b;
  logic          dir_a, dir_b, en, word, stb_q;

  wire hit      = xfer_req & xfer_ack;
  wire stb_rise = stb & ~stb_q;

  assign pa_oe = dir_a;
  assign pb_oe = word ? dir_a : dir_b;

  always_comb begin
    rdata = '0;
    case (reg_sel)
      2'd0: rdata = word ? {in_b, in_a} : {{PW{1'b0}}, in_a};
      2'd1: rdata = {{PW{1'b0}}, in_b};
      2'd2: rdata[1:0] = {dir_b, dir_a};
      default: rdata[2:0] = {word, 1'b0, en};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_out <= '0; pb_out <= '0; in_a <= '0; in_b <= '0;
      dir_a <= 1'b0; dir_b <= 1'b0; en <= 1'b0; word <= 1'b0;
      stb_q <= 1'b0; xfer_req <= 1'b0;
    end else begin
      stb_q    <= stb;
      xfer_req <= en & ~hit;
      if (wr_en) begin
        case (reg_sel)
          2'd0: begin
            pa_out <= wdata[PW-1:0];
            if (word) pb_out <= wdata[DW-1:PW];
          end
          2'd1: pb_out <= wdata[PW-1:0];
          2'd2: begin dir_a <= wdata[0]; dir_b <= wdata[1]; end
          default: begin en <= wdata[0]; word <= wdata[2]; end
        endcase
      end
      if (stb_rise) begin
        in_a <= pa_in;
        in_b <= pb_in;
      end
      if (hit) begin
        if (dir_a) begin
          pa_out <= wdata[PW-1:0];
          if (word) pb_out <= wdata[DW-1:PW];
        end else begin
          in_a <= pa_in;
          if (word) in_b <= pb_in;
        end
      end
    end
  end
endmodule

// File: rtl/pio_dual_port_chk.sv
module pio_dual_port_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_sel,
  input logic          wr_en,
  input logic          stb,
  input logic          stb_q,
  input logic          xfer_req,
  input logic          xfer_ack,
  input logic          en,
  input logic          word,
  input logic          pa_oe,
  input logic          pb_oe,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] in_a,
  input logic [PW-1:0] in_b
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!pa_oe && !pb_oe && !xfer_req));

  p_word_b_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word |-> (pb_oe == pa_oe));

  p_no_req_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !xfer_req);

  p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack) |=> !xfer_req);

  p_byte_keeps_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !word && !(wr_en && reg_sel == 2'd1)) |=> $stable(pb_out));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(stb && !stb_q) && !(xfer_req && xfer_ack)) |=> ($stable(in_a) && $stable(in_b)));
endmodule

bind pio_dual_port pio_dual_port_chk #(.PW(PW)) chk (.*);

// File: tb/pio_dual_port_test.sv
module pio_dual_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic wr_en = 1'b0, stb = 1'b0, xfer_ack = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic xfer_req, pa_oe, pb_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pa_out, pb_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int id; logic [15:0] v; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  pio_dual_port uut (.*);

  function automatic logic [15:0] observe(int id);
    case (id)
      0: return rdata;
      1: return {8'h00, pa_out};
      2: return {8'h00, pb_out};
      3: return {14'b0, pb_oe, pa_oe};
      default: return {15'b0, xfer_req};
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = observe(it.id);
      checks++;
      if (act !== it.v) begin
        errors++;
        $display("FAIL %s: signal %0d actual %h expected %h", it.tag, it.id, act, it.v);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_val(int id, logic [15:0] v, string tag);
    item_t it;
    it.id = id; it.v = v; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    reg_sel = sel; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic ack_once(logic [15:0] d);
    wdata = d; xfer_ack = 1'b1;
    tick();
    xfer_ack = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, logic [15:0] v, string tag);
    reg_sel = sel;
    expect_val(0, v, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    expect_val(3, 16'h0, "R1 oe in reset");
    expect_val(4, 16'h0, "R1 req in reset");
    rst_n = 1'b1;
    tick();
    rd(2'd3, 16'h0000, "R1 ctrl after reset");
    rd(2'd2, 16'h0000, "R1 dir after reset");

    wr(2'd2, 16'h0001); expect_val(3, 16'h1, "R2 A out");
    wr(2'd2, 16'h0002); expect_val(3, 16'h2, "R2 B out");
    wr(2'd2, 16'h0003); expect_val(3, 16'h3, "R2 both out");

    wr(2'd1, 16'h00C3); expect_val(2, 16'h00C3, "R10 write sel1");
    wr(2'd0, 16'hFF5A);
    expect_val(1, 16'h005A, "R10 byte write A");
    expect_val(2, 16'h00C3, "R10 byte write leaves B");
    rd(2'd2, 16'h0003, "R11 dir readback");

    wr(2'd3, 16'h0004);
    rd(2'd3, 16'h0004, "R11 ctrl readback");
    wr(2'd2, 16'h0002); expect_val(3, 16'h0, "R3 B bit ignored");
    wr(2'd2, 16'h0001); expect_val(3, 16'h3, "R3 B follows A");
    wr(2'd0, 16'hBEEF);
    expect_val(1, 16'h00EF, "R8 word low byte");
    expect_val(2, 16'h00BE, "R8 word high byte");

    pa_in = 8'h12; pb_in = 8'h34; stb = 1'b1;
    tick();
    stb = 1'b0; pa_in = 8'h99; pb_in = 8'h88;
    tick(); tick();
    rd(2'd0, 16'h3412, "R9 R8 strobe capture word read");
    wr(2'd3, 16'h0000);
    rd(2'd0, 16'h0012, "R10 byte read A");
    rd(2'd1, 16'h0034, "R10 byte read B");

    tick(); tick();
    expect_val(4, 16'h0, "R4 no req while disabled");
    wr(2'd3, 16'h0001);
    expect_val(4, 16'h0, "R5 req not yet");
    tick();
    expect_val(4, 16'h1, "R5 req raised");
    ack_once(16'h7711);
    expect_val(4, 16'h0, "R5 req dropped");
    expect_val(1, 16'h0011, "R6 byte dma drives A");
    expect_val(2, 16'h00BE, "R6 byte dma keeps B");
    tick();
    expect_val(4, 16'h1, "R5 req again");

    wr(2'd2, 16'h0000);
    pa_in = 8'h5C; pb_in = 8'h6D;
    ack_once(16'h0000);
    rd(2'd0, 16'h005C, "R7 byte dma captures A");
    rd(2'd1, 16'h0034, "R7 byte dma leaves B");

    wr(2'd3, 16'h0005);
    tick();
    pa_in = 8'h01; pb_in = 8'h02;
    ack_once(16'h0000);
    rd(2'd0, 16'h0201, "R7 word dma captures both");

    wr(2'd2, 16'h0001);
    tick();
    ack_once(16'hA55A);
    expect_val(1, 16'h005A, "R8 word dma low byte");
    expect_val(2, 16'h00A5, "R8 word dma high byte");

    wr(2'd3, 16'h0000);
    tick();
    expect_val(4, 16'h0, "R4 req gone after disable");
    wr(2'd2, 16'h0000);
    pa_in = 8'hEE;
    ack_once(16'h0000);
    rd(2'd0, 16'h0001, "R4 ack without request ignored");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule